// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the program counter of a processor whose instruction memory is addressed in words. It works out the following fetch address every cycle. A decoder supplies a transfer class together with the immediate bits of the instruction, the second instruction word, the 16-bit pointer register and the negative and overflow flags. The unit picks one of five sources for the next address: the plain successor, an absolute 22-bit target, the pointer register, a relative jump, or a relative branch taken on signed greater-or-equal.

The address chosen for the next fetch is available on `next_pc_o` in the same cycle as the inputs. The counter `pc_o` takes that value on the next rising clock edge. Both relative forms measure their offset from the successor address (counter plus one), not from the counter itself. All address arithmetic wraps modulo 2^22.

Top module: `pcnx_unit`

## Requirements
- R1: An active-low asynchronous reset clears `pc_o` to 0, and the counter stays at 0 while reset is held.
- R2: Class code 0 (sequential) and the unassigned codes 5, 6 and 7 all give a next address of `pc_o` + 1.
- R3: Class code 1 (absolute) gives a next address whose upper 6 bits come from `fld_i[5:0]` and whose lower 16 bits come from `ext_i`.
- R4: Class code 2 (indirect) gives a next address equal to `zreg_i`, zero-extended to 22 bits.
- R5: Class code 3 (relative jump) reads `fld_i[11:0]` as a two's-complement offset from -2048 to +2047 and gives `pc_o` + 1 + offset.
- R6: Class code 4 (signed greater-or-equal branch) reads `fld_i[6:0]` as a two's-complement offset from -64 to +63. When `flag_n_i` equals `flag_v_i` the branch is taken and the next address is `pc_o` + 1 + offset. When the flags differ, the next address is `pc_o` + 1.
- R7: Every sum wraps modulo 2^22: the successor of 0x3FFFFF is 0, and an offset that runs past either end of the space wraps around.
- R8: `next_pc_o` is combinational from the current inputs and `pc_o`, and `pc_o` equals that value one rising edge later.
- R9: Bits of `fld_i` above those a class uses have no effect: bits 11:6 for the absolute class and bits 11:7 for the branch class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_class_i | input | 3 | Transfer class code |
| fld_i | input | 12 | Immediate bits of the first instruction word |
| ext_i | input | 16 | Second instruction word (low target bits) |
| zreg_i | input | 16 | Pointer register value for indirect jumps |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| next_pc_o | output | 22 | Address selected for the next fetch |
| pc_o | output | 22 | Program counter register |

## Verification
`next_pc_o` is due in the same cycle as its stimulus, because only combinational logic lies between the inputs and this output. `pc_o` is due after exactly one rising edge. The bench drives each stimulus just after a falling edge and reads `next_pc_o` a nanosecond later. It then waits for the following falling edge and reads `pc_o` there, so both results are sampled half a cycle away from the register's update. The bench follows the counter with its own model, which is updated only from the expected values. Every case therefore starts from a known address, and the bench reaches that address through absolute jumps.

// File: rtl/pcnx_pkg.sv
package pcnx_pkg;

  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_ABS  = 3'd1,
    CLS_IND  = 3'd2,
    CLS_REL  = 3'd3,
    CLS_BRGE = 3'd4
  } xfer_cls_e;

  // Map a raw class code onto a known class; spare codes fall back to sequential.
  function automatic xfer_cls_e decode_cls(input logic [2:0] code);
    xfer_cls_e c;
    case (code)
      3'd1:    c = CLS_ABS;
      3'd2:    c = CLS_IND;
      3'd3:    c = CLS_REL;
      3'd4:    c = CLS_BRGE;
      default: c = CLS_SEQ;
    endcase
    return c;
  endfunction

  // Signed greater-or-equal holds when negative and overflow agree.
  function automatic logic signed_ge(input logic neg, input logic ovf);
    return ~(neg ^ ovf);
  endfunction

endpackage

// File: rtl/pcnx_cond.sv
module pcnx_cond
  import pcnx_pkg::*;
(
  input  xfer_cls_e cls_i,
  input  logic      flag_n_i,
  input  logic      flag_v_i,
  output logic      br_take_o
);

  logic ge_hit;

  assign ge_hit    = signed_ge(flag_n_i, flag_v_i);
  assign br_take_o = (cls_i == CLS_BRGE) && ge_hit;

endmodule

// File: rtl/pcnx_targets.sv
module pcnx_targets #(
  parameter int PC_W  = 22,
  parameter int Z_W   = 16,
  parameter int REL_W = 12,
  parameter int BR_W  = 7,
  parameter int HI_W  = 6,
  parameter int EXT_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [REL_W-1:0] fld_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [Z_W-1:0]   zreg_i,
  output logic [PC_W-1:0]  seq_pc_o,
  output logic [PC_W-1:0]  abs_pc_o,
  output logic [PC_W-1:0]  ind_pc_o,
  output logic [PC_W-1:0]  rel_pc_o,
  output logic [PC_W-1:0]  br_pc_o
);

  localparam int REL_PAD = PC_W - REL_W;
  localparam int BR_PAD  = PC_W - BR_W;
  localparam int ABS_W   = HI_W + EXT_W;

  function automatic logic [PC_W-1:0] widen_rel(input logic [REL_W-1:0] x);
    return {{REL_PAD{x[REL_W-1]}}, x};
  endfunction

  function automatic logic [PC_W-1:0] widen_br(input logic [BR_W-1:0] x);
    return {{BR_PAD{x[BR_W-1]}}, x};
  endfunction

  // Successor-relative sum; the adder width gives the wrap for free.
  function automatic logic [PC_W-1:0] from_succ(input logic [PC_W-1:0] base,
                                                input logic [PC_W-1:0] delta);
    return base + delta + PC_W'(1);
  endfunction

  logic [ABS_W-1:0] abs_raw;

  assign abs_raw  = {fld_i[HI_W-1:0], ext_i};
  assign abs_pc_o = PC_W'(abs_raw);
  assign seq_pc_o = from_succ(pc_i, '0);
  assign rel_pc_o = from_succ(pc_i, widen_rel(fld_i));
  assign br_pc_o  = from_succ(pc_i, widen_br(fld_i[BR_W-1:0]));

  generate
    if (Z_W < PC_W) begin : g_zext
      assign ind_pc_o = {{(PC_W-Z_W){1'b0}}, zreg_i};
    end else begin : g_ztrunc
      assign ind_pc_o = zreg_i[PC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pcnx_select.sv
module pcnx_select
  import pcnx_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  xfer_cls_e       cls_i,
  input  logic            br_take_i,
  input  logic [PC_W-1:0] seq_pc_i,
  input  logic [PC_W-1:0] abs_pc_i,
  input  logic [PC_W-1:0] ind_pc_i,
  input  logic [PC_W-1:0] rel_pc_i,
  input  logic [PC_W-1:0] br_pc_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            xfer_taken_o
);

  always_comb begin
    next_pc_o    = seq_pc_i;
    xfer_taken_o = 1'b0;
    case (cls_i)
      CLS_ABS: begin
        next_pc_o    = abs_pc_i;
        xfer_taken_o = 1'b1;
      end
      CLS_IND: begin
        next_pc_o    = ind_pc_i;
        xfer_taken_o = 1'b1;
      end
      CLS_REL: begin
        next_pc_o    = rel_pc_i;
        xfer_taken_o = 1'b1;
      end
      CLS_BRGE: begin
        if (br_take_i) begin
          next_pc_o    = br_pc_i;
          xfer_taken_o = 1'b1;
        end
      end
      default: begin
        next_pc_o    = seq_pc_i;
        xfer_taken_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pcnx_unit.sv
module pcnx_unit
  import pcnx_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int Z_W   = 16,
  parameter int REL_W = 12,
  parameter int BR_W  = 7,
  parameter int HI_W  = 6,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_class_i,
  input  logic [REL_W-1:0] fld_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [Z_W-1:0]   zreg_i,
  input  logic             flag_n_i,
  input  logic             flag_v_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [PC_W-1:0]  pc_o
);

  xfer_cls_e       cls;
  logic            br_take;
  logic            xfer_taken;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] abs_pc;
  logic [PC_W-1:0] ind_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] br_pc;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  assign cls = decode_cls(op_class_i);

  pcnx_cond u_cond (
    .cls_i     (cls),
    .flag_n_i  (flag_n_i),
    .flag_v_i  (flag_v_i),
    .br_take_o (br_take)
  );

  pcnx_targets #(
    .PC_W (PC_W), .Z_W (Z_W), .REL_W (REL_W),
    .BR_W (BR_W), .HI_W (HI_W), .EXT_W (EXT_W)
  ) u_targets (
    .pc_i     (pc_q),
    .fld_i    (fld_i),
    .ext_i    (ext_i),
    .zreg_i   (zreg_i),
    .seq_pc_o (seq_pc),
    .abs_pc_o (abs_pc),
    .ind_pc_o (ind_pc),
    .rel_pc_o (rel_pc),
    .br_pc_o  (br_pc)
  );

  pcnx_select #(.PC_W (PC_W)) u_select (
    .cls_i        (cls),
    .br_take_i    (br_take),
    .seq_pc_i     (seq_pc),
    .abs_pc_i     (abs_pc),
    .ind_pc_i     (ind_pc),
    .rel_pc_i     (rel_pc),
    .br_pc_i      (br_pc),
    .next_pc_o    (pc_d),
    .xfer_taken_o (xfer_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign next_pc_o = pc_d;
  assign pc_o      = pc_q;

endmodule

// File: rtl/pcnx_unit_chk.sv
module pcnx_unit_chk
  import pcnx_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int Z_W   = 16,
  parameter int REL_W = 12,
  parameter int BR_W  = 7,
  parameter int HI_W  = 6,
  parameter int EXT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_class_i,
  input logic [REL_W-1:0] fld_i,
  input logic [EXT_W-1:0] ext_i,
  input logic [Z_W-1:0]   zreg_i,
  input logic             flag_n_i,
  input logic             flag_v_i,
  input logic [PC_W-1:0]  next_pc_o,
  input logic [PC_W-1:0]  pc_o,
  input logic             br_take,
  input logic             xfer_taken
);

  logic [PC_W-1:0] e_succ;
  logic [PC_W-1:0] e_abs;
  logic [PC_W-1:0] e_ind;
  logic [PC_W-1:0] e_rel;
  logic [PC_W-1:0] e_br;
  logic            spare_cls;

  always_comb begin
    e_succ    = PC_W'(pc_o + PC_W'(1));
    e_abs     = PC_W'(fld_i[HI_W-1:0]) << EXT_W | PC_W'(ext_i);
    e_ind     = PC_W'(zreg_i);
    e_rel     = PC_W'(e_succ + PC_W'($signed(fld_i)));
    e_br      = PC_W'(e_succ + PC_W'($signed(fld_i[BR_W-1:0])));
    spare_cls = (op_class_i == 3'd0) || (op_class_i > 3'd4);
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> pc_o == '0);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spare_cls |=> pc_o == $past(e_succ));

  p_quiet_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_taken |=> pc_o == $past(e_succ));

  p_abs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_class_i == 3'd1 |=> pc_o == $past(e_abs));

  p_ind_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_class_i == 3'd2 |=> pc_o == $past(e_ind));

  p_rel_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_class_i == 3'd3 |=> pc_o == $past(e_rel));

  p_br_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class_i == 3'd4 && flag_n_i == flag_v_i) |=> pc_o == $past(e_br));

  p_br_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class_i == 3'd4 && flag_n_i != flag_v_i) |=> pc_o == $past(e_succ));

  p_br_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |-> (op_class_i == 3'd4 && flag_n_i == flag_v_i));

  p_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_cls && pc_o == {PC_W{1'b1}}) |=> pc_o == '0);

  p_next_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_o == $past(next_pc_o));

endmodule

bind pcnx_unit pcnx_unit_chk #(
  .PC_W (PC_W), .Z_W (Z_W), .REL_W (REL_W),
  .BR_W (BR_W), .HI_W (HI_W), .EXT_W (EXT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_class_i (op_class_i),
  .fld_i      (fld_i),
  .ext_i      (ext_i),
  .zreg_i     (zreg_i),
  .flag_n_i   (flag_n_i),
  .flag_v_i   (flag_v_i),
  .next_pc_o  (next_pc_o),
  .pc_o       (pc_o),
  .br_take    (br_take),
  .xfer_taken (xfer_taken)
);

// File: tb/pcnx_unit_tb.sv
`timescale 1ns/1ps
module pcnx_unit_tb;

  localparam int SPACE = 4194304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_class_i;
  logic [11:0] fld_i;
  logic [15:0] ext_i;
  logic [15:0] zreg_i;
  logic        flag_n_i;
  logic        flag_v_i;
  logic [21:0] next_pc_o;
  logic [21:0] pc_o;

  int checks   = 0;
  int failures = 0;
  int cur_pc   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pcnx_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_class_i (op_class_i),
    .fld_i      (fld_i),
    .ext_i      (ext_i),
    .zreg_i     (zreg_i),
    .flag_n_i   (flag_n_i),
    .flag_v_i   (flag_v_i),
    .next_pc_o  (next_pc_o),
    .pc_o       (pc_o)
  );

  function automatic int wrap_addr(input int v);
    return ((v % SPACE) + SPACE) % SPACE;
  endfunction

  // Bench-side reading of a signed field of the given width.
  function automatic int as_signed(input int raw, input int bits);
    int lim;
    lim = 1 << bits;
    raw = raw % lim;
    return (raw >= lim / 2) ? raw - lim : raw;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [2:0] c, input logic [11:0] f, input logic [15:0] e,
                      input logic [15:0] z, input logic n, input logic v,
                      input int exp, input string tag);
    op_class_i = c; fld_i = f; ext_i = e; zreg_i = z; flag_n_i = n; flag_v_i = v;
    #1;
    check(next_pc_o == 22'(exp), {tag, " next_pc_o (R8)"}, int'(next_pc_o), exp);
    @(negedge clk);
    check(pc_o == 22'(exp), {tag, " pc_o"}, int'(pc_o), exp);
    cur_pc = exp;
  endtask

  task automatic go_abs(input int target, input logic [11:0] hi_junk, input string tag);
    logic [11:0] f;
    f = hi_junk | 12'(target / 65536);
    step(3'd1, f, 16'(target % 65536), 16'h0, 1'b0, 1'b0, target, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_class_i = 3'd0; fld_i = '0; ext_i = '0; zreg_i = '0; flag_n_i = 0; flag_v_i = 0;
    repeat (3) @(negedge clk);
    check(pc_o == 22'd0, "R1 reset value", int'(pc_o), 0);
    rst_n = 1'b1;
    cur_pc = 0;
  endtask

  task automatic t_seq;
    step(3'd0, 12'hFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, cur_pc + 1, "R2 sequential code 0");
    step(3'd5, 12'h7FF, 16'h1234, 16'h0, 1'b0, 1'b0, cur_pc + 1, "R2 spare code 5");
    step(3'd7, 12'h800, 16'h0, 16'h0, 1'b0, 1'b0, cur_pc + 1, "R2 spare code 7");
  endtask

  task automatic t_abs;
    go_abs(22'h3FFFFF, 12'h000, "R3 absolute max");
    go_abs(22'h2A5A5A, 12'h000, "R3 absolute pattern");
    go_abs(22'h000001, 12'hFC0, "R9 absolute upper field bits ignored");
  endtask

  task automatic t_ind;
    step(3'd2, 12'hFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 65535, "R4 indirect max");
    step(3'd2, 12'h000, 16'h0, 16'h0000, 1'b0, 1'b0, 0, "R4 indirect zero");
  endtask

  task automatic t_rel;
    go_abs(5000, 12'h0, "R5 setup");
    step(3'd3, 12'h7FF, 16'h0, 16'h0, 1'b0, 1'b0,
         wrap_addr(cur_pc + 1 + as_signed(12'h7FF, 12)), "R5 relative +2047");
    step(3'd3, 12'h800, 16'h0, 16'h0, 1'b0, 1'b0,
         wrap_addr(cur_pc + 1 + as_signed(12'h800, 12)), "R5 relative -2048");
    step(3'd3, 12'hFFF, 16'h0, 16'h0, 1'b0, 1'b0, cur_pc, "R5 relative -1 stays");
  endtask

  task automatic t_brge;
    go_abs(1000, 12'h0, "R6 setup");
    step(3'd4, 12'h03F, 16'h0, 16'h0, 1'b0, 1'b0, cur_pc + 64, "R6 taken +63 n0 v0");
    step(3'd4, 12'h040, 16'h0, 16'h0, 1'b1, 1'b1, cur_pc + 1 - 64, "R6 taken -64 n1 v1");
    step(3'd4, 12'h03F, 16'h0, 16'h0, 1'b1, 1'b0, cur_pc + 1, "R6 not taken n1 v0");
    step(3'd4, 12'h040, 16'h0, 16'h0, 1'b0, 1'b1, cur_pc + 1, "R6 not taken n0 v1");
    step(3'd4, 12'hF83, 16'h0, 16'h0, 1'b0, 1'b0, cur_pc + 1 + 3,
         "R9 branch upper field bits ignored");
  endtask

  task automatic t_wrap;
    go_abs(22'h3FFFFF, 12'h0, "R7 setup top");
    step(3'd0, 12'h0, 16'h0, 16'h0, 1'b0, 1'b0, 0, "R7 successor wraps to 0");
    go_abs(22'h3FFFFF, 12'h0, "R7 setup top again");
    step(3'd3, 12'h7FF, 16'h0, 16'h0, 1'b0, 1'b0, 2047, "R7 relative forward wrap");
    go_abs(10, 12'h0, "R7 setup low");
    step(3'd4, 12'h040, 16'h0, 16'h0, 1'b0, 1'b0,
         wrap_addr(10 + 1 - 64), "R7 branch backward wrap");
  endtask

  task automatic t_reset_mid;
    go_abs(777, 12'h0, "R1 setup");
    rst_n = 1'b0;
    #1;
    check(pc_o == 22'd0, "R1 asynchronous clear", int'(pc_o), 0);
    @(negedge clk);
    check(pc_o == 22'd0, "R1 held in reset", int'(pc_o), 0);
    rst_n = 1'b1;
    cur_pc = 0;
    step(3'd0, 12'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1, "R2 first step after reset");
  endtask

  initial begin
    t_reset();
    t_seq();
    t_abs();
    t_ind();
    t_rel();
    t_brge();
    t_wrap();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule